// File: doc/BRIEF.md
# Four-Master Priority Bus Arbiter

This block decides which of four masters on a shared, tightly coupled multiprocessor bus owns that bus. Every master drives an active-low request line. The arbiter answers on four active-low grant lines, and at most one of them is low at any time. The arbiter also watches the shared active-low busy and lock lines, which the masters drive. From those two lines it tells whether the bus is free, is running an ordinary cycle, or is held by a locked sequence. Priority is fixed: master 0 ranks highest and master 3 lowest.

The arbiter decides only who holds the grant. A master treats the bus as available only when three things hold together: its grant is low, busy is high and lock is high. It then starts its cycle on the next clock and drops its request once that cycle has begun. While a locked sequence runs, the grant can already move to a higher-priority requester. That master still has to wait until the lock is released. An optional gap mode makes any handover from one master to another pass through one clock with no grant, so the previous owner has time to release the shared lines.

The grant is a register. It changes on the clock edge after the inputs that cause the change are sampled. Reset is asynchronous and active low.

Top module: `arb_bus_arbiter`

## Requirements
- R1: During reset, and after reset until a request is sampled low, all grant lines are high.
- R2: When busy and lock are both high, the grant goes on the next clock to the lowest-numbered master whose request is low (bit i of the request and grant vectors belongs to master i).
- R3: At most one grant line is low in any cycle.
- R4: While busy is low and lock is high, the grant does not change, whatever the requests do.
- R5: While lock is low and a grant is held, the grant stays with its holder as long as no lower-numbered master requests. This holds even when the holder drops its request or busy returns high.
- R6: While lock is low, a request from a master numbered lower than the current holder moves the grant to the lowest-numbered requester on the next clock.
- R7: When busy and lock are high and no request is low, all grant lines go high on the next clock.
- R8: With gap mode on (gap input high), the grant never passes directly from one master to another. At least one clock with all grant lines high lies between two owners. A grant given from the no-grant state is not delayed.
- R9: With gap mode off, a handover between two masters takes a single clock, with no clock in between that has no grant.
- R10: While lock is low and no grant is held, the grant goes to the lowest-numbered requester on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gap_en | input | 1 | High: insert one clock with no grant between two different owners |
| bus_req_n | input | 4 | Request per master, active low, bit 0 highest priority |
| bus_busy_n | input | 1 | Shared bus-busy line, active low |
| bus_lock_n | input | 1 | Shared bus-lock line, active low |
| bus_gnt_n | output | 4 | Grant per master, active low, at most one low |

## Verification
All sixteen request patterns are applied while the bus is free. This separates a correct lowest-index pick from a reversed or unordered encoder. The same contending patterns are then repeated while busy is low, while lock is low, and while lock is low with no grant held. This shows whether the grant is frozen, kept by its holder, taken by a higher-priority master, or given fresh. Handovers are driven with gap mode both on and off, including a takeover during a lock, so that a missing or extra no-grant clock shows up. A behavioural model follows every clock and compares the grant lines in each cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Condition of the shared bus as seen from its busy and lock lines.
  typedef enum logic [1:0] {
    BUS_FREE = 2'd0,   // neither busy nor locked
    BUS_RUN  = 2'd1,   // ordinary cycle in progress
    BUS_HELD = 2'd2    // locked sequence in progress
  } bus_state_e;

endpackage

// File: rtl/arb_bus_state.sv
module arb_bus_state
  import arb_pkg::*;
(
  input  logic       busy_n,
  input  logic       lock_n,
  output bus_state_e state
);

  // Lock dominates: a locked sequence keeps ownership across cycle boundaries.
  always_comb begin
    if (!lock_n)      state = BUS_HELD;
    else if (!busy_n) state = BUS_RUN;
    else              state = BUS_FREE;
  end

endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] act,
  output logic [N-1:0] win
);

  // seen[i] is high when any lower-numbered (higher priority) line is active.
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pick
    assign win[i]    = act[i] & ~seen[i];
    assign seen[i+1] = seen[i] | act[i];
  end

endmodule

// File: rtl/arb_grant_next.sv
module arb_grant_next
  import arb_pkg::*;
#(
  parameter int N = 4
) (
  input  bus_state_e   state,
  input  logic         gap_en,
  input  logic [N-1:0] owner,
  input  logic [N-1:0] win,
  output logic [N-1:0] nxt
);

  localparam logic [N-1:0] NONE = '0;

  // outranks[i] is high when the current owner sits above index i.
  logic [N:0]   owner_above;
  logic [N-1:0] outranks;
  assign owner_above[N] = 1'b0;

  for (genvar i = N - 1; i >= 0; i--) begin : g_rank
    assign outranks[i]    = owner_above[i+1];
    assign owner_above[i] = owner_above[i+1] | owner[i];
  end

  logic         preempt;
  logic [N-1:0] target;

  assign preempt = |(win & outranks);

  always_comb begin
    unique case (state)
      BUS_HELD: target = ((owner == NONE) || preempt) ? win : owner;
      BUS_RUN:  target = owner;
      default:  target = win;
    endcase

    nxt = target;
    if (gap_en && (owner != NONE) && (target != NONE) && (target != owner)) begin
      nxt = NONE;
    end
  end

endmodule

// File: rtl/arb_bus_arbiter.sv
module arb_bus_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   gap_en,
  input  logic [NUM_MASTERS-1:0] bus_req_n,
  input  logic                   bus_busy_n,
  input  logic                   bus_lock_n,
  output logic [NUM_MASTERS-1:0] bus_gnt_n
);

  localparam int N = NUM_MASTERS;

  bus_state_e   state;
  logic [N-1:0] win;
  logic [N-1:0] owner_q;
  logic [N-1:0] owner_d;

  arb_bus_state u_state (
    .busy_n (bus_busy_n),
    .lock_n (bus_lock_n),
    .state  (state)
  );

  arb_prio_pick #(.N(N)) u_pick (
    .act (~bus_req_n),
    .win (win)
  );

  arb_grant_next #(.N(N)) u_next (
    .state  (state),
    .gap_en (gap_en),
    .owner  (owner_q),
    .win    (win),
    .nxt    (owner_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= '0;
    else        owner_q <= owner_d;
  end

  assign bus_gnt_n = ~owner_q;

endmodule

// File: rtl/arb_bus_arbiter_chk.sv
module arb_bus_arbiter_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         gap_en,
  input logic [N-1:0] bus_req_n,
  input logic         bus_busy_n,
  input logic         bus_lock_n,
  input logic [N-1:0] bus_gnt_n
);

  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] holder;
  logic [N-1:0] active;
  logic [N-1:0] lowest;
  logic [N-1:0] above_holder;

  assign holder       = ~bus_gnt_n;
  assign active       = ~bus_req_n;
  assign lowest       = active & (~active + ONE);
  assign above_holder = holder - ONE;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_gnt_n)); // R3

  AST_RUN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_busy_n && bus_lock_n) |=> $stable(bus_gnt_n)); // R4

  AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_lock_n && (holder != '0) && ((active & above_holder) == '0))
      |=> $stable(bus_gnt_n)); // R5

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy_n && bus_lock_n && (&bus_req_n)) |=> (&bus_gnt_n)); // R7

  AST_FREE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy_n && bus_lock_n && (holder == '0) && (active != '0))
      |=> (~bus_gnt_n == $past(lowest))); // R2

  AST_GAP_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_en && (holder != '0))
      |=> ((bus_gnt_n == $past(bus_gnt_n)) || (&bus_gnt_n))); // R8

endmodule

bind arb_bus_arbiter arb_bus_arbiter_chk #(.N(NUM_MASTERS)) u_arb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gap_en     (gap_en),
  .bus_req_n  (bus_req_n),
  .bus_busy_n (bus_busy_n),
  .bus_lock_n (bus_lock_n),
  .bus_gnt_n  (bus_gnt_n)
);

// File: tb/test_arb_bus_arbiter.sv
module test_arb_bus_arbiter;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       gap_en;
  logic [3:0] bus_req_n;
  logic       bus_busy_n;
  logic       bus_lock_n;
  logic [3:0] bus_gnt_n;

  int checks   = 0;
  int failures = 0;
  int owner    = -1;   // reference model: index of granted master, -1 none
  bit done     = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  arb_bus_arbiter #(.NUM_MASTERS(4)) i_arb_bus_arbiter (
    .clk        (clk),
    .rst_n      (rst_n),
    .gap_en     (gap_en),
    .bus_req_n  (bus_req_n),
    .bus_busy_n (bus_busy_n),
    .bus_lock_n (bus_lock_n),
    .bus_gnt_n  (bus_gnt_n)
  );

  function automatic int first_req(input logic [3:0] r);
    for (int i = 0; i < 4; i++) if (!r[i]) return i;
    return -1;
  endfunction

  // Behavioural reference, advanced once per rising edge.
  task automatic model_step();
    int w;
    int t;
    w = first_req(bus_req_n);
    if (!rst_n) begin
      owner = -1;
      return;
    end
    if (!bus_lock_n) begin
      if (owner < 0)                 t = w;
      else if (w >= 0 && w < owner)  t = w;
      else                           t = owner;
    end else if (!bus_busy_n) begin
      t = owner;
    end else begin
      t = w;
    end
    if (gap_en && owner >= 0 && t >= 0 && t != owner) t = -1;
    owner = t;
  endtask

  task automatic compare(input string tag);
    logic [3:0] exp;
    exp = 4'b1111;
    if (owner >= 0) exp[owner] = 1'b0;
    checks++;
    if (bus_gnt_n !== exp) begin
      failures++;
      $display("FAIL %s: gnt_n actual=%b expected=%b", tag, bus_gnt_n, exp);
    end
    checks++;
    if ($countones(~bus_gnt_n) > 1) begin
      failures++;
      $display("FAIL R3: gnt_n actual=%b expected at most one low", bus_gnt_n);
    end
  endtask

  task automatic cyc(input logic [3:0] r, input logic b, input logic l,
                     input logic g, input string tag);
    bus_req_n  = r;
    bus_busy_n = b;
    bus_lock_n = l;
    gap_en     = g;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    rst_n      = 1'b0;
    gap_en     = 1'b0;
    bus_req_n  = 4'b1111;
    bus_busy_n = 1'b1;
    bus_lock_n = 1'b1;
    @(negedge clk);
    // R1: requests during reset are ignored
    cyc(4'b0000, 1, 1, 0, "R1 in reset");
    cyc(4'b1010, 1, 1, 0, "R1 in reset");
    rst_n = 1'b1;
    cyc(4'b1111, 1, 1, 0, "R1 after reset");
    cyc(4'b1111, 1, 1, 0, "R1 after reset");

    // R2: every request pattern on a free bus
    for (int p = 0; p < 16; p++) begin
      cyc(4'(p), 1, 1, 0, "R2 priority pick");
      cyc(4'(p), 1, 1, 0, "R2 priority pick");
    end

    // R4: busy freezes the grant even when master 0 asks
    cyc(4'b1011, 1, 1, 0, "R2 grant to 2");
    cyc(4'b1011, 0, 1, 0, "R4 busy hold");
    cyc(4'b1010, 0, 1, 0, "R4 busy hold");
    cyc(4'b1010, 0, 1, 0, "R4 busy hold");
    cyc(4'b1010, 1, 1, 0, "R9 boundary handover");

    // R7: no request, busy returns high
    cyc(4'b1111, 0, 1, 0, "R4 busy hold");
    cyc(4'b1111, 1, 1, 0, "R7 release");
    cyc(4'b1111, 1, 1, 0, "R7 release");

    // R5 and R6: lock keeps the holder unless a higher master asks
    cyc(4'b1011, 1, 1, 0, "R2 grant to 2");
    cyc(4'b1011, 0, 0, 0, "R5 lock keep");
    cyc(4'b0111, 0, 0, 0, "R5 lock keep lower req");
    cyc(4'b0111, 1, 0, 0, "R5 lock keep busy high");
    cyc(4'b0101, 0, 0, 0, "R6 lock preempt");
    cyc(4'b0101, 0, 0, 0, "R5 lock keep new holder");
    cyc(4'b1111, 1, 1, 0, "R7 release");

    // R10: locked bus with no holder
    cyc(4'b1011, 0, 0, 0, "R10 locked fresh grant");
    cyc(4'b1011, 0, 0, 0, "R5 lock keep");
    cyc(4'b1111, 1, 1, 0, "R7 release");

    // R8: gap mode on a free bus and during a lock takeover
    cyc(4'b0111, 1, 1, 1, "R8 fresh grant undelayed");
    cyc(4'b0110, 1, 1, 1, "R8 gap clock");
    cyc(4'b0110, 1, 1, 1, "R8 after gap");
    cyc(4'b1111, 1, 1, 1, "R7 release");
    cyc(4'b1011, 1, 1, 1, "R8 fresh grant undelayed");
    cyc(4'b1011, 0, 0, 1, "R5 lock keep");
    cyc(4'b1001, 0, 0, 1, "R8 gap in lock takeover");
    cyc(4'b1001, 0, 0, 1, "R8 after gap");
    cyc(4'b1111, 1, 1, 1, "R7 release");

    // R9: gap mode off, direct handover
    cyc(4'b0111, 1, 1, 0, "R2 grant to 3");
    cyc(4'b0110, 1, 1, 0, "R9 direct handover");
    cyc(4'b1111, 1, 1, 0, "R7 release");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule